// File: doc/BRIEF.md
# Unaligned Bitstream Peek Reader

This block sits at the head of a bitstream decoder. It takes 128-bit quadwords from a DMA-style producer through a ready/valid push port and queues them in a small input FIFO. Up to two quadwords move from that FIFO into a working buffer, one quadword per cycle. A 7-bit pointer marks the next unread bit of the oldest buffered quadword. The block always shows the 32 stream bits that begin at the pointer, so a decoder can look ahead without consuming anything. A separate advance request then consumes between 0 and 63 bits.

The stream is read byte by byte: byte 0 of a quadword comes first, and within each byte the most significant bit comes first. A window can start on any bit and can run across byte boundaries and quadword boundaries. The block refuses a window when fewer than 32 bits are buffered. It refuses an advance when the request is longer than the buffered data. A clear request flushes every buffer and loads the pointer with a given value. This lets a new stream start at any bit offset of its first quadword. A packed status word reports the position state.

Top module: `bsr_reader`

## Requirements
- R1: While reset is held and after it is released, status reads 0, peek_ok is 0, both data outputs read 0 and qw_ready is 1.
- R2: Stream order: byte j of a quadword is qw_data[8j+7:8j], byte 0 is read first, and bit 7 of each byte is read first. Stream bit i after the pointer appears at peek_word[31-i], whether the pointer is aligned to a byte or not. The 32-bit window may cross byte boundaries and run from the current quadword into the next one.
- R3: peek_raw is peek_word with its four bytes reversed, so the first stream byte sits in peek_raw[7:0].
- R4: Available bits = 128 × buffered count − pointer, with a floor of 0. peek_ok is 1 exactly when 32 or more bits are available. While peek_ok is 0, peek_word and peek_raw both read 0.
- R5: An advance of N bits (adv_len, 0 to 63) takes effect only when N is no more than the available bits. A refused advance leaves the pointer and the buffered data unchanged.
- R6: An advance that carries the pointer to 128 or beyond retires the current quadword. The next quadword becomes current and the pointer wraps modulo 128.
- R7: The working buffer holds at most two quadwords. While it holds fewer than two and the FIFO is not empty, one quadword moves across from the FIFO every cycle.
- R8: qw_ready is 1 exactly when the FIFO is not full and no clear is requested. A push is accepted only when qw_ready is 1, and the FIFO count never exceeds FIFO_DEPTH.
- R9: A clear empties the FIFO and the working buffer and loads the pointer from clr_ptr. A push or an advance presented in the same cycle as a clear has no effect.
- R10: Status layout: bits 6:0 hold the pointer, bits 15:8 the FIFO quadword count and bits 17:16 the buffered quadword count. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qw_valid | input | 1 | Producer offers a quadword |
| qw_data | input | 128 | Offered quadword |
| qw_ready | output | 1 | Quadword is accepted this cycle |
| adv_valid | input | 1 | Advance request |
| adv_len | input | 6 | Number of bits to consume |
| clr_valid | input | 1 | Clear all position state |
| clr_ptr | input | 7 | Pointer value loaded by a clear |
| peek_ok | output | 1 | At least 32 bits are available |
| peek_word | output | 32 | Window at the pointer, first stream bit at bit 31 |
| peek_raw | output | 32 | Same window with its bytes reversed |
| status | output | 32 | Packed pointer and occupancy word |

## Verification
The case that is hardest to reach is a window or an advance that straddles the end of the current quadword while the second buffer slot has just been refilled. This needs a pointer above 96 and two quadwords in the working buffer. A related case is a clear that loads a high pointer into an empty buffer, where the first quadword alone does not give 32 bits. Directed steps build both cases on purpose: one clear loads pointer 100, and a second clear loads pointer 127 ahead of unaligned advances. The random phase chains advances of up to 63 bits, so pointer wraps with uneven remainders happen often. A reference model in the bench extracts each bit one at a time and checks every step against the design.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int QW_BITS   = 128;
    localparam int PTR_W     = 7;
    localparam int WORD_BITS = 32;
    localparam int PAIR_BITS = 2 * QW_BITS;
    localparam int AVAIL_W   = 9;

    typedef logic [QW_BITS-1:0]   qword_t;
    typedef logic [PTR_W-1:0]     bitptr_t;
    typedef logic [WORD_BITS-1:0] word_t;

    typedef struct packed {
        logic [13:0] rsvd_hi;
        logic [1:0]  buf_cnt;
        logic [7:0]  fifo_cnt;
        logic        rsvd_lo;
        bitptr_t     ptr;
    } status_t;

    function automatic word_t byte_swap32(word_t w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Lay out two quadwords as a serial stream: stream byte j sits at the top-down slot j.
    function automatic logic [PAIR_BITS-1:0] stream_order(qword_t first, qword_t second);
        logic [PAIR_BITS-1:0] pair;
        logic [PAIR_BITS-1:0] res;
        pair = {second, first};
        for (int j = 0; j < PAIR_BITS / 8; j++) begin
            res[PAIR_BITS-1-8*j -: 8] = pair[8*j +: 8];
        end
        return res;
    endfunction

    function automatic logic [AVAIL_W-1:0] avail_bits(logic [1:0] cnt, bitptr_t ptr);
        logic [AVAIL_W-1:0] total;
        total = {cnt, 7'd0};
        return (total >= AVAIL_W'(ptr)) ? (total - AVAIL_W'(ptr)) : '0;
    endfunction

endpackage

// File: rtl/bsr_infifo.sv
module bsr_infifo #(
    parameter int DEPTH = 4,
    parameter int W     = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] step(logic [AW-1:0] i);
        return (i == AW'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_idx <= step(wr_idx);
            if (pop)  rd_idx <= step(rd_idx);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rd_idx];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/bsr_stage.sv
module bsr_stage
    import bsr_pkg::*;
#(
    parameter int ADV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  bitptr_t          clr_ptr,
    input  logic             adv_valid,
    input  logic [ADV_W-1:0] adv_len,
    input  logic             fifo_empty,
    input  qword_t           fifo_data,
    output logic             fifo_pop,
    output qword_t           slot0,
    output qword_t           slot1,
    output logic [1:0]       buf_cnt,
    output bitptr_t          ptr
);
    logic [1:0]         cnt_q, cnt_mid;
    bitptr_t            ptr_q;
    qword_t             s0_q, s1_q;
    logic [AVAIL_W-1:0] avail;
    logic [PTR_W:0]     sum;
    logic               adv_ok, retire;

    always_comb begin
        avail    = avail_bits(cnt_q, ptr_q);
        adv_ok   = adv_valid && !clr && (AVAIL_W'(adv_len) <= avail);
        sum      = {1'b0, ptr_q} + (PTR_W+1)'(adv_len);
        retire   = adv_ok && sum[PTR_W];
        cnt_mid  = cnt_q - 2'(retire);
        fifo_pop = !clr && !fifo_empty && (cnt_mid < 2'd2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            ptr_q <= clr_ptr;
        end else begin
            cnt_q <= cnt_mid + 2'(fifo_pop);
            if (adv_ok) ptr_q <= sum[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (retire) s0_q <= s1_q;
        if (fifo_pop) begin
            if (cnt_mid == 2'd0) s0_q <= fifo_data;
            else                 s1_q <= fifo_data;
        end
    end

    assign slot0   = s0_q;
    assign slot1   = s1_q;
    assign buf_cnt = cnt_q;
    assign ptr     = ptr_q;
endmodule

// File: rtl/bsr_window.sv
module bsr_window
    import bsr_pkg::*;
(
    input  qword_t  q0,
    input  qword_t  q1,
    input  bitptr_t ptr,
    input  logic    ok,
    output word_t   word_be,
    output word_t   word_raw
);
    logic [PAIR_BITS-1:0] strm, shifted;
    word_t                win;

    always_comb begin
        strm     = stream_order(q0, q1);
        shifted  = strm << ptr;
        win      = shifted[PAIR_BITS-1 -: WORD_BITS];
        word_be  = ok ? win : '0;
        word_raw = byte_swap32(word_be);
    end
endmodule

// File: rtl/bsr_reader.sv
module bsr_reader
    import bsr_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int ADV_W      = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               qw_valid,
    input  logic [127:0]       qw_data,
    output logic               qw_ready,
    input  logic               adv_valid,
    input  logic [ADV_W-1:0]   adv_len,
    input  logic               clr_valid,
    input  logic [6:0]         clr_ptr,
    output logic               peek_ok,
    output logic [31:0]        peek_word,
    output logic [31:0]        peek_raw,
    output logic [31:0]        status
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    logic           f_full, f_empty, f_pop, f_push;
    logic [FCW-1:0] f_cnt;
    qword_t         f_dout, s0, s1;
    logic [1:0]     bcnt;
    bitptr_t        ptr;
    status_t        st;

    assign qw_ready = !f_full && !clr_valid;
    assign f_push   = qw_valid && qw_ready;

    bsr_infifo #(.DEPTH(FIFO_DEPTH), .W(QW_BITS)) u_fifo (
        .clk(clk), .rst(rst), .flush(clr_valid),
        .push(f_push), .din(qw_data), .pop(f_pop),
        .dout(f_dout), .count(f_cnt), .full(f_full), .empty(f_empty)
    );

    bsr_stage #(.ADV_W(ADV_W)) u_stage (
        .clk(clk), .rst(rst), .clr(clr_valid), .clr_ptr(clr_ptr),
        .adv_valid(adv_valid), .adv_len(adv_len),
        .fifo_empty(f_empty), .fifo_data(f_dout), .fifo_pop(f_pop),
        .slot0(s0), .slot1(s1), .buf_cnt(bcnt), .ptr(ptr)
    );

    assign peek_ok = (avail_bits(bcnt, ptr) >= AVAIL_W'(WORD_BITS));

    bsr_window u_win (
        .q0(s0), .q1(s1), .ptr(ptr), .ok(peek_ok),
        .word_be(peek_word), .word_raw(peek_raw)
    );

    always_comb begin
        st          = '0;
        st.ptr      = ptr;
        st.fifo_cnt = 8'(f_cnt);
        st.buf_cnt  = bcnt;
    end
    assign status = st;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker
    import bsr_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int ADV_W      = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             qw_ready,
    input logic             adv_valid,
    input logic [ADV_W-1:0] adv_len,
    input logic             clr_valid,
    input logic [6:0]       clr_ptr,
    input logic             peek_ok,
    input logic [31:0]      peek_word,
    input logic [31:0]      peek_raw,
    input logic [31:0]      status
);
    status_t            st;
    logic [AVAIL_W-1:0] av;
    assign st = status;
    assign av = avail_bits(st.buf_cnt, st.ptr);

    p_buf_max_r7: assert property (@(posedge clk) disable iff (rst)
        st.buf_cnt <= 2'd2);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        st.fifo_cnt <= 8'(FIFO_DEPTH));

    p_full_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (st.fifo_cnt == 8'(FIFO_DEPTH)) |-> !qw_ready);

    p_ok_level_r4: assert property (@(posedge clk) disable iff (rst)
        peek_ok == (av >= AVAIL_W'(32)));

    p_refused_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !peek_ok |-> (peek_word == '0 && peek_raw == '0));

    p_swap_r3: assert property (@(posedge clk) disable iff (rst)
        peek_raw[7:0] == peek_word[31:24] && peek_raw[31:24] == peek_word[7:0]);

    p_refused_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (adv_valid && !clr_valid && AVAIL_W'(adv_len) > av) |=> $stable(st.ptr));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> (st.ptr == $past(clr_ptr) && st.buf_cnt == 2'd0 && st.fifo_cnt == 8'd0));

    p_status_rsvd_r10: assert property (@(posedge clk) disable iff (rst)
        st.rsvd_hi == '0 && st.rsvd_lo == 1'b0);
endmodule

bind bsr_reader bsr_checker #(.FIFO_DEPTH(FIFO_DEPTH), .ADV_W(ADV_W)) u_chk (
    .clk(clk), .rst(rst), .qw_ready(qw_ready),
    .adv_valid(adv_valid), .adv_len(adv_len),
    .clr_valid(clr_valid), .clr_ptr(clr_ptr),
    .peek_ok(peek_ok), .peek_word(peek_word), .peek_raw(peek_raw),
    .status(status)
);

// File: tb/test_bsr_reader.sv
`timescale 1ns/1ps
module test_bsr_reader;
    localparam int DEPTH = 4;
    localparam int CAP   = DEPTH + 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         qw_valid;
    logic [127:0] qw_data;
    logic         qw_ready;
    logic         adv_valid;
    logic [5:0]   adv_len;
    logic         clr_valid;
    logic [6:0]   clr_ptr;
    logic         peek_ok;
    logic [31:0]  peek_word, peek_raw, status;

    int n_vec  = 0;
    int n_fail = 0;

    logic [127:0] mq[$];
    int           mptr = 0;

    always #2.5 clk = ~clk;

    bsr_reader #(.FIFO_DEPTH(DEPTH), .ADV_W(6)) i_bsr_reader (
        .clk(clk), .rst(rst), .qw_valid(qw_valid), .qw_data(qw_data),
        .qw_ready(qw_ready), .adv_valid(adv_valid), .adv_len(adv_len),
        .clr_valid(clr_valid), .clr_ptr(clr_ptr), .peek_ok(peek_ok),
        .peek_word(peek_word), .peek_raw(peek_raw), .status(status)
    );

    function automatic int m_buf();
        return (mq.size() > 2) ? 2 : mq.size();
    endfunction

    function automatic int m_avail();
        int t;
        t = 128 * m_buf() - mptr;
        return (t < 0) ? 0 : t;
    endfunction

    // Reference extraction, one bit at a time in stream order.
    function automatic logic [31:0] m_window();
        logic [31:0]  w;
        logic [127:0] q;
        int b;
        w = '0;
        if (m_avail() < 32) return w;
        for (int i = 0; i < 32; i++) begin
            b = mptr + i;
            q = (b < 128) ? mq[0] : mq[1];
            w[31-i] = q[8*((b % 128) / 8) + (7 - (b % 8))];
        end
        return w;
    endfunction

    function automatic logic [31:0] m_status();
        return {14'd0, 2'(m_buf()), 8'(mq.size() - m_buf()), 1'b0, 7'(mptr)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check_all(string req);
        logic [31:0] w;
        @(negedge clk);
        w = m_window();
        chk("R10", "status", status, m_status());
        chk("R4", "peek_ok", 32'(peek_ok), 32'(m_avail() >= 32));
        chk(req, "peek_word", peek_word, w);
        chk("R3", "peek_raw", peek_raw, {w[7:0], w[15:8], w[23:16], w[31:24]});
    endtask

    task automatic push(logic [127:0] d, string req);
        logic exp_rdy;
        @(negedge clk);
        exp_rdy = (mq.size() < CAP);
        chk("R8", "qw_ready", 32'(qw_ready), 32'(exp_rdy));
        qw_valid = 1'b1;
        qw_data  = d;
        tick(1);
        qw_valid = 1'b0;
        if (exp_rdy) mq.push_back(d);
        tick(3);
        check_all(req);
    endtask

    task automatic advance(int n, string req);
        adv_valid = 1'b1;
        adv_len   = 6'(n);
        tick(1);
        adv_valid = 1'b0;
        if (n <= m_avail()) begin
            mptr += n;
            if (mptr >= 128) begin
                void'(mq.pop_front());
                mptr -= 128;
            end
        end
        tick(3);
        check_all(req);
    endtask

    task automatic clear(int v);
        clr_valid = 1'b1;
        clr_ptr   = 7'(v);
        qw_valid  = 1'b1;
        qw_data   = {4{32'hDEAD_BEEF}};
        adv_valid = 1'b1;
        adv_len   = 6'd8;
        tick(1);
        clr_valid = 1'b0;
        qw_valid  = 1'b0;
        adv_valid = 1'b0;
        mq.delete();
        mptr = v;
        tick(3);
        check_all("R9");
    endtask

    function automatic logic [127:0] ramp(int base);
        logic [127:0] q;
        for (int j = 0; j < 16; j++) q[8*j +: 8] = 8'(base + j);
        return q;
    endfunction

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250120));
        rst = 1'b1; qw_valid = 1'b0; qw_data = '0; adv_valid = 1'b0;
        adv_len = '0; clr_valid = 1'b0; clr_ptr = '0;
        tick(3);
        @(negedge clk);
        chk("R1", "status in reset", status, 32'd0);
        rst = 1'b0;
        tick(1);
        @(negedge clk);
        chk("R1", "status", status, 32'd0);
        chk("R1", "peek_ok", 32'(peek_ok), 32'd0);
        chk("R1", "peek_word", peek_word, 32'd0);
        chk("R1", "qw_ready", 32'(qw_ready), 32'd1);

        // R2 aligned read of a known ramp, then unaligned and cross-quadword reads
        push(ramp(8'h00), "R2");
        push(ramp(8'h10), "R2");
        chk("R2", "aligned word", peek_word, 32'h0001_0203);
        advance(5, "R2");
        advance(63, "R2");
        advance(50, "R2");
        advance(13, "R6");
        // R5 refusal: drain to under 64 bits, then ask for more than is left
        advance(63, "R5");
        advance(63, "R5");
        advance(63, "R5");
        // R8 fill to capacity and try one more
        for (int i = 0; i < CAP + 1; i++) push(ramp(32 * i), "R8");
        // R4 boundary: high pointer into an empty buffer
        clear(100);
        push(ramp(8'h40), "R4");
        push(ramp(8'h80), "R2");
        advance(28, "R6");
        clear(127);
        push(ramp(8'hA0), "R4");
        push(ramp(8'hC0), "R2");
        advance(1, "R6");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 40)      push({$urandom, $urandom, $urandom, $urandom}, "R7");
            else if (r < 97) advance($urandom_range(0, 63), "R5");
            else             clear($urandom_range(0, 127));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule